// File: doc/BRIEF.md
# Numeric Coprocessor Busy and Error Latch

This block sits between a 16-bit processor and its numeric coprocessor. The coprocessor's active-low busy line normally passes straight through to the processor. If the coprocessor signals an unmasked exception on its active-low error line while it is busy, the block holds the processor-side busy line low. The line stays low after the coprocessor finishes, so the processor cannot issue further coprocessor instructions. An active-high interrupt request stays raised for as long as the hold is in place.

Software releases the hold by writing to one of two I/O ports. A write to 0x00F0 only releases the hold. A write to 0x00F1 releases it and also sends a reset pulse of fixed length to the coprocessor. The I/O write strobe is synchronised and edge-detected inside the block, so one write cycle yields one event however long the strobe stays low. A system reset clears the hold and holds the coprocessor in reset.

Top module: `npx_busy_ctrl`

## Requirements
- R1: While no error is held, `cpu_busy_n` equals `cop_busy_n` in the same cycle.
- R2: If `cop_err_n` and `cop_busy_n` are both low at a rising clock edge, the error is held from that edge on: `cpu_busy_n` is low and `err_irq` is high.
- R3: A held error keeps `cpu_busy_n` low after `cop_busy_n` and `cop_err_n` return high, until a clearing write takes effect.
- R4: A write to port 0x00F0 releases the hold and leaves `cop_reset` low.
- R5: A write to port 0x00F1 releases the hold and drives `cop_reset` high for exactly RST_PULSE clock cycles (default 4), starting at the edge where the write takes effect.
- R6: A write is decoded only when `io_space` is 1 and all 16 bits of `io_addr` equal a port number. Any other address, or `io_space` at 0, has no effect.
- R7: A write takes effect at the third rising clock edge after `iow_n` falls. A strobe that stays low for many cycles produces exactly one event.
- R8: While `rst` is high, `cop_reset` is high. A reset clears the held error.
- R9: If a clearing write takes effect at the same edge where an error-while-busy is sampled, the error stays held.
- R10: An error with `cop_busy_n` high at the sampling edge does not set the hold.
- R11: `err_irq` is high exactly while an error is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous system reset, active high |
| io_addr | input | 16 | I/O address bus |
| io_space | input | 1 | High when the current cycle addresses I/O space |
| iow_n | input | 1 | I/O write strobe, active low |
| cop_busy_n | input | 1 | Coprocessor busy, active low |
| cop_err_n | input | 1 | Coprocessor unmasked error, active low |
| cpu_busy_n | output | 1 | Busy to the processor, active low |
| cop_reset | output | 1 | Reset to the coprocessor, active high |
| err_irq | output | 1 | Error interrupt request, active high |

## Verification
The hardest case to reach is a collision: a clearing write taking effect at the same edge where a new error arrives while the coprocessor is busy. The write only lands three edges after the strobe falls. The bench therefore holds error and busy low across the whole write window in a directed case. In the random phase it toggles error and busy around each write, and a cycle-level reference model decides the expected hold state at every edge. A long strobe followed by a count of reset-pulse cycles covers the case where a single write must not re-trigger the pulse.

// File: rtl/npx_pkg.sv
package npx_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_CLEAR = 2'd1,
    WR_RESET = 2'd2
  } npx_wr_e;
endpackage

// File: rtl/npx_wr_decode.sv
module npx_wr_decode
  import npx_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CLR_PORT  = 'h0F0,
  parameter logic [ADDR_W-1:0] RST_PORT  = 'h0F1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_space,
  input  logic              iow_n,
  output npx_wr_e           wr_ev
);
  localparam int HIST_W = SYNC_STAGES + 1;

  logic [HIST_W-1:0] strobe_hist;
  logic              strobe_fall;

  always_ff @(posedge clk) begin
    if (rst) strobe_hist <= '1;
    else     strobe_hist <= {strobe_hist[HIST_W-2:0], iow_n};
  end

  assign strobe_fall = !strobe_hist[SYNC_STAGES-1] && strobe_hist[SYNC_STAGES];

  always_comb begin
    wr_ev = WR_NONE;
    if (strobe_fall && io_space) begin
      if (io_addr == CLR_PORT)      wr_ev = WR_CLEAR;
      else if (io_addr == RST_PORT) wr_ev = WR_RESET;
    end
  end

  p_single_event_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ev != WR_NONE) |=> (wr_ev == WR_NONE));
endmodule

// File: rtl/npx_err_latch.sv
module npx_err_latch
  import npx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cop_busy_n,
  input  logic    cop_err_n,
  input  npx_wr_e wr_ev,
  output logic    err_held
);
  logic set_cond;

  assign set_cond = !cop_busy_n && !cop_err_n;

  always_ff @(posedge clk) begin
    if (rst)                    err_held <= 1'b0;
    else if (set_cond)          err_held <= 1'b1;
    else if (wr_ev != WR_NONE)  err_held <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    set_cond |=> err_held);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (err_held && wr_ev == WR_NONE) |=> err_held);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_ev != WR_NONE && !set_cond) |=> !err_held);
  p_priority_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_ev != WR_NONE && set_cond) |=> err_held);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    (!err_held && !set_cond) |=> !err_held);
endmodule

// File: rtl/npx_rst_pulse.sv
module npx_rst_pulse
  import npx_pkg::*;
#(
  parameter int RST_PULSE = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  npx_wr_e wr_ev,
  output logic    cop_reset
);
  localparam int CW = $clog2(RST_PULSE + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_PULSE);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                    remain <= '0;
    else if (wr_ev == WR_RESET) remain <= LOAD;
    else if (remain != '0)      remain <= remain - 1'b1;
  end

  assign cop_reset = rst || (remain != '0);

  p_pulse_start_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_ev == WR_RESET) |=> cop_reset);
  p_pulse_bound_r5: assert property (@(posedge clk) disable iff (rst)
    remain <= LOAD);
  p_clear_no_reset_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_ev == WR_CLEAR && remain == '0) |=> !cop_reset);
endmodule

// File: rtl/npx_busy_ctrl.sv
module npx_busy_ctrl
  import npx_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter int                RST_PULSE   = 4,
  parameter logic [ADDR_W-1:0] CLR_PORT    = 'h0F0,
  parameter logic [ADDR_W-1:0] RST_PORT    = 'h0F1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_space,
  input  logic              iow_n,
  input  logic              cop_busy_n,
  input  logic              cop_err_n,
  output logic              cpu_busy_n,
  output logic              cop_reset,
  output logic              err_irq
);
  npx_wr_e wr_ev;
  logic    err_held;

  npx_wr_decode #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .CLR_PORT(CLR_PORT), .RST_PORT(RST_PORT)
  ) u_decode (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_space(io_space),
    .iow_n(iow_n), .wr_ev(wr_ev)
  );

  npx_err_latch u_latch (
    .clk(clk), .rst(rst), .cop_busy_n(cop_busy_n), .cop_err_n(cop_err_n),
    .wr_ev(wr_ev), .err_held(err_held)
  );

  npx_rst_pulse #(.RST_PULSE(RST_PULSE)) u_pulse (
    .clk(clk), .rst(rst), .wr_ev(wr_ev), .cop_reset(cop_reset)
  );

  assign cpu_busy_n = cop_busy_n && !err_held;
  assign err_irq    = err_held;

  p_follow_r1: assert property (@(posedge clk) disable iff (rst)
    !err_irq |-> (cpu_busy_n == cop_busy_n));
  p_busy_held_r3: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> !cpu_busy_n);
  p_sys_reset_r8: assert property (@(posedge clk)
    rst |-> cop_reset);
endmodule

// File: tb/npx_busy_ctrl_tb.sv
module npx_busy_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0000;
  logic        io_space = 1'b0;
  logic        iow_n = 1'b1;
  logic        cop_busy_n = 1'b1;
  logic        cop_err_n = 1'b1;
  logic        cpu_busy_n, cop_reset, err_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R8";
  bit    chk_en = 1'b0;
  bit    done = 1'b0;

  localparam int PULSE = 4;

  // reference state
  logic [2:0] m_hist = 3'b111;
  bit         m_lat = 1'b0;
  int         m_cnt = 0;

  always #10 clk = ~clk;

  npx_busy_ctrl u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_space(io_space),
    .iow_n(iow_n), .cop_busy_n(cop_busy_n), .cop_err_n(cop_err_n),
    .cpu_busy_n(cpu_busy_n), .cop_reset(cop_reset), .err_irq(err_irq)
  );

  always @(posedge clk) begin
    bit fall, ev_c, ev_r, set_c;
    cycles++;
    if (rst) begin
      m_hist = 3'b111; m_lat = 1'b0; m_cnt = 0;
    end else begin
      fall  = !m_hist[1] && m_hist[2];
      ev_c  = fall && io_space && io_addr == 16'h00F0;
      ev_r  = fall && io_space && io_addr == 16'h00F1;
      set_c = !cop_busy_n && !cop_err_n;
      if (set_c)             m_lat = 1'b1;
      else if (ev_c || ev_r) m_lat = 1'b0;
      if (ev_r)              m_cnt = PULSE;
      else if (m_cnt > 0)    m_cnt = m_cnt - 1;
      m_hist = {m_hist[1:0], iow_n};
    end
    chk_en = 1'b1;
    if (cycles > 200000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (chk_en) begin
      check({cur_tag, " cpu_busy_n"}, cpu_busy_n, cop_busy_n & !m_lat);
      check({cur_tag, " cop_reset"}, cop_reset, rst | (m_cnt != 0));
      check({cur_tag, " err_irq R11"}, err_irq, m_lat);
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic write_port(logic [15:0] a, logic sp, int hold);
    io_addr = a; io_space = sp; iow_n = 1'b0;
    cyc(hold);
    iow_n = 1'b1;
    cyc(3);
    io_space = 1'b0;
  endtask

  task automatic make_error();
    cop_busy_n = 1'b0; cop_err_n = 1'b0;
    cyc(1);
    cop_err_n = 1'b1; cop_busy_n = 1'b1;
    cyc(1);
  endtask

  initial begin
    int pulse_len;
    void'($urandom(32'd2024));
    cyc(3);
    @(negedge clk);
    check("R8 reset holds coprocessor reset", cop_reset, 1'b1);
    check("R8 reset clears hold", err_irq, 1'b0);
    cyc(1);
    rst = 1'b0;

    cur_tag = "R1";
    for (int i = 0; i < 6; i++) begin
      cop_busy_n = i[0];
      cyc(1);
    end
    cop_busy_n = 1'b1;

    cur_tag = "R10";
    cop_err_n = 1'b0; cyc(3); cop_err_n = 1'b1; cyc(1);
    @(negedge clk);
    check("R10 error without busy ignored", err_irq, 1'b0);

    cur_tag = "R2";
    make_error();
    @(negedge clk);
    check("R2 hold set", err_irq, 1'b1);
    check("R3 busy stays low after release", cpu_busy_n, 1'b0);
    cur_tag = "R3";
    cyc(5);

    cur_tag = "R6";
    write_port(16'h00F0, 1'b0, 2);
    write_port(16'h00F2, 1'b1, 2);
    write_port(16'h10F0, 1'b1, 2);
    @(negedge clk);
    check("R6 mismatched writes ignored", err_irq, 1'b1);
    check("R6 no reset from mismatched write", cop_reset, 1'b0);

    cur_tag = "R4";
    write_port(16'h00F0, 1'b1, 2);
    @(negedge clk);
    check("R4 clear port releases hold", err_irq, 1'b0);
    check("R4 clear port gives no reset", cop_reset, 1'b0);

    cur_tag = "R7";
    make_error();
    io_addr = 16'h00F1; io_space = 1'b1; iow_n = 1'b0;
    cyc(2);
    @(negedge clk);
    check("R7 no effect before third edge", err_irq, 1'b1);
    cyc(1);
    pulse_len = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (cop_reset) pulse_len++;
      cyc(1);
    end
    iow_n = 1'b1; cyc(3); io_space = 1'b0;
    checks++;
    if (pulse_len != PULSE) begin
      errors++;
      $display("FAIL R5 pulse length: actual=%0d expected=%0d", pulse_len, PULSE);
    end
    check("R5 reset port releases hold", err_irq, 1'b0);

    cur_tag = "R9";
    make_error();
    io_addr = 16'h00F0; io_space = 1'b1; iow_n = 1'b0;
    cop_busy_n = 1'b0; cop_err_n = 1'b0;
    cyc(4);
    cop_busy_n = 1'b1; cop_err_n = 1'b1; iow_n = 1'b1;
    cyc(1);
    @(negedge clk);
    check("R9 new error wins over clear", err_irq, 1'b1);
    cyc(3); io_space = 1'b0;

    cur_tag = "R8";
    rst = 1'b1; cyc(2);
    @(negedge clk);
    check("R8 reset output during reset", cop_reset, 1'b1);
    check("R8 hold cleared by reset", err_irq, 1'b0);
    rst = 1'b0; cyc(1);

    cur_tag = "R1 random";
    for (int it = 0; it < 600; it++) begin
      int n;
      int sel;
      n = 1 + int'($urandom_range(5));
      for (int k = 0; k < n; k++) begin
        cop_busy_n = $urandom_range(2) != 0;
        cop_err_n  = $urandom_range(4) != 0;
        cyc(1);
      end
      sel = int'($urandom_range(5));
      case (sel)
        0: io_addr = 16'h00F0;
        1: io_addr = 16'h00F1;
        2: io_addr = 16'h00F2;
        3: io_addr = 16'($urandom);
        default: io_addr = 16'h00F0;
      endcase
      io_space = $urandom_range(5) != 0;
      iow_n = 1'b0;
      for (int k = 0; k < 1 + int'($urandom_range(4)); k++) begin
        cop_busy_n = $urandom_range(2) != 0;
        cop_err_n  = $urandom_range(3) != 0;
        cyc(1);
      end
      iow_n = 1'b1;
      cyc(3);
      io_space = 1'b0;
      if ($urandom_range(60) == 0) begin
        rst = 1'b1; cyc(1); rst = 1'b0;
      end
    end

    cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule